// File: doc/BRIEF.md
# Self-Timed Bit-Serial Adder

This block adds two N-bit operands (32 by default) and a carry-in, one bit position per loop iteration. It is organised as a network of storage links, each holding a value and a full/empty flag. Between the links sit joints: small handshake actions. A joint may act on a clock edge only when its own go input is high and its guard holds. The guard requires every link it reads to be full and every link it writes to be empty. Because each joint has an independent go bit, a caller can drive any interleaving of joint firings. The block must still deliver the correct sum for every such interleaving. This lets a bench or an enclosing scheduler model variable delays.

The operands enter through a valid/ready handshake and are loaded into two shift registers. Each iteration runs as follows. The control joint issues a request token to each operand source. Each source moves its low bit into a one-bit link. The add joint combines both bits with the carry link. The carry-out is fed back into the carry link, and the sum bit is shifted into an accumulator. The count link then advances. When the count reaches N and the carry has settled, the result joint writes the final carry above the N sum bits into a result link. That result link drives the output stream.

Input back-pressure: `in_ready` is high only when every internal link is empty and the result link is empty, so the block accepts at most one operand set at a time. Output back-pressure: once `res_valid` is high it stays high, with `res_data` unchanged, until `res_ready` is seen.

Top module: `st_serial_adder`

## Requirements
- R1: After reset, `in_ready` is 1 and `res_valid` is 0.
- R2: An accepted transfer (`in_valid` and `in_ready` high at a rising edge) makes `in_ready` 0 from the next cycle. It stays 0 until the result handshake completes.
- R3: Changes on `in_a`, `in_b`, `in_cin` or `in_valid` while `in_ready` is 0 have no effect on the result that is delivered.
- R4: `res_data` equals `in_a + in_b + in_cin` as a 33-bit (N+1) value. Bit N holds the final carry. This holds for any schedule of the go inputs.
- R5: A joint acts only in a cycle where its go bit is high. The bits are: bit 0 operand-A transfer, bit 1 operand-B transfer, bit 2 iteration start, bit 3 count update, bit 4 add, bit 5 carry feedback, bit 6 sum shift, bit 7 result write. With all go bits low, no result appears.
- R6: With every go bit held high, `res_valid` rises on the (5N+1)-th rising edge after the accepting edge.
- R7: While `res_valid` is 1 and `res_ready` is 0, `res_valid` stays 1 and `res_data` is stable. `in_ready` returns to 1 in the cycle after the result handshake.
- R8: `res_valid` is 1 only between an accepted transfer and its result handshake. The iteration count never exceeds N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Block is quiescent and its result link is empty |
| in_a | input | N | First operand |
| in_b | input | N | Second operand |
| in_cin | input | 1 | Carry-in |
| go_i | input | 8 | One enable per joint, bit mapping as in R5 |
| res_valid | output | 1 | Result link is full |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | N+1 | Final carry (bit N) above the N sum bits |

## Verification
The hardest situation to reach is an iteration in which the carry feedback lags behind the next operand bits. The sum shift may also complete long before the count update. Each go bit is therefore driven from a fresh random value every cycle, so that these orderings occur often across many operand sets. A stall phase holds all go bits low in the middle of an addition. Other phases present changing operands while the block is busy, and hold the consumer off for a random number of cycles. In every phase the bench model tracks which handshake should come next and what sum is owed.

// File: rtl/st_adder_pkg.sv
`timescale 1ns/1ps
package st_adder_pkg;

  // joint enable positions on go_i
  typedef enum int unsigned {
    J_OPA   = 0,
    J_OPB   = 1,
    J_START = 2,
    J_UPD   = 3,
    J_ADD   = 4,
    J_CARRY = 5,
    J_SUM   = 6,
    J_RES   = 7
  } joint_e;

  localparam int NJ = 8;

  // returns {carry_out, sum}
  function automatic logic [1:0] full_add(input logic a, input logic b, input logic c);
    full_add = {(a & b) | (a & c) | (b & c), a ^ b ^ c};
  endfunction

endpackage

// File: rtl/st_link.sv
`timescale 1ns/1ps
// Storage link: a value plus a full/empty flag.
module st_link #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fill,
  input  logic         drain,
  input  logic [W-1:0] din,
  output logic         full,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      dout <= '0;
    end else if (fill) begin
      full <= 1'b1;
      dout <= din;
    end else if (drain) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/st_token.sv
`timescale 1ns/1ps
// Data-less link: only the full/empty flag.
module st_token (
  input  logic clk,
  input  logic rst_n,
  input  logic fill,
  input  logic drain,
  output logic full
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     full <= 1'b0;
    else if (fill)  full <= 1'b1;
    else if (drain) full <= 1'b0;
  end
endmodule

// File: rtl/st_shift_src.sv
`timescale 1ns/1ps
// Operand source: shift register, request token, and one-bit output link.
module st_shift_src #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [N-1:0] load_val,
  input  logic         go,
  input  logic         issue,
  input  logic         take,
  output logic         req_full,
  output logic         bit_full,
  output logic         bit_val
);
  logic [N-1:0] sreg;
  logic         fire;

  assign fire = go & req_full & ~bit_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sreg <= '0;
    else if (load)  sreg <= load_val;
    else if (fire)  sreg <= sreg >> 1;
  end

  st_token u_req (
    .clk(clk), .rst_n(rst_n), .fill(issue), .drain(fire), .full(req_full)
  );

  st_link #(.W(1)) u_bit (
    .clk(clk), .rst_n(rst_n), .fill(fire), .drain(take),
    .din(sreg[0]), .full(bit_full), .dout(bit_val)
  );
endmodule

// File: rtl/st_ctrl.sv
`timescale 1ns/1ps
// Iteration control: count link, in-flight count buffer, sum-done token.
module st_ctrl #(
  parameter int N  = 32,
  parameter int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          go_start,
  input  logic          go_upd,
  input  logic          reqs_idle,
  input  logic          sum_mark,
  input  logic          finish,
  output logic          iter_start,
  output logic          ctl_full,
  output logic          ctl2_full,
  output logic          mark_full,
  output logic          at_end,
  output logic [CW-1:0] count
);
  logic [CW-1:0] ctl2_q;
  logic [CW-1:0] ctl_din;
  logic          upd;

  assign at_end     = ctl_full && (count == CW'(N));
  assign iter_start = go_start & ctl_full & (count != CW'(N)) & ~ctl2_full & reqs_idle;
  assign upd        = go_upd & ctl2_full & mark_full & ~ctl_full;
  assign ctl_din    = load ? '0 : ctl2_q + CW'(1);

  st_link #(.W(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .fill(load | upd), .drain(iter_start | finish),
    .din(ctl_din), .full(ctl_full), .dout(count)
  );

  st_link #(.W(CW)) u_cnt_buf (
    .clk(clk), .rst_n(rst_n), .fill(iter_start), .drain(upd),
    .din(count), .full(ctl2_full), .dout(ctl2_q)
  );

  st_token u_mark (
    .clk(clk), .rst_n(rst_n), .fill(sum_mark), .drain(upd), .full(mark_full)
  );
endmodule

// File: rtl/st_serial_adder.sv
`timescale 1ns/1ps
module st_serial_adder
  import st_adder_pkg::*;
#(
  parameter int N  = 32,
  localparam int CW = $clog2(N + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [N-1:0]      in_a,
  input  logic [N-1:0]      in_b,
  input  logic              in_cin,
  input  logic [NJ-1:0]     go_i,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [N:0]        res_data
);
  logic          load;
  logic [N-1:0]  opnd [2];
  logic [1:0]    req_full, bit_full, bit_val;
  logic          iter_start, ctl_full, ctl2_full, mark_full, at_end;
  logic [CW-1:0] ctl_count;
  logic          lc_full, lc_q, ls_full, ls_q, lco_full, lco_q;
  logic [1:0]    fa_out;
  logic [N-1:0]  acc;
  logic          fire_add, fire_carry, fire_sum, fire_res, quiet;

  assign load    = in_valid & in_ready;
  assign opnd[0] = in_a;
  assign opnd[1] = in_b;

  // two operand sources, one per go bit J_OPA / J_OPB
  for (genvar g = 0; g < 2; g++) begin : g_src
    st_shift_src #(.N(N)) u_src (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(opnd[g]),
      .go(go_i[g]), .issue(iter_start), .take(fire_add),
      .req_full(req_full[g]), .bit_full(bit_full[g]), .bit_val(bit_val[g])
    );
  end

  st_ctrl #(.N(N), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .load(load),
    .go_start(go_i[J_START]), .go_upd(go_i[J_UPD]),
    .reqs_idle(~|req_full), .sum_mark(fire_sum), .finish(fire_res),
    .iter_start(iter_start), .ctl_full(ctl_full), .ctl2_full(ctl2_full),
    .mark_full(mark_full), .at_end(at_end), .count(ctl_count)
  );

  // joint guards
  assign fire_add   = go_i[J_ADD] & (&bit_full) & lc_full & ~ls_full & ~lco_full;
  assign fire_carry = go_i[J_CARRY] & lco_full & ~lc_full;
  assign fire_sum   = go_i[J_SUM] & ls_full & ~mark_full;
  assign fire_res   = go_i[J_RES] & at_end & lc_full & ~res_valid;

  assign fa_out = full_add(bit_val[0], bit_val[1], lc_q);

  st_link #(.W(1)) u_carry (
    .clk(clk), .rst_n(rst_n), .fill(load | fire_carry), .drain(fire_add | fire_res),
    .din(load ? in_cin : lco_q), .full(lc_full), .dout(lc_q)
  );

  st_link #(.W(1)) u_cout (
    .clk(clk), .rst_n(rst_n), .fill(fire_add), .drain(fire_carry),
    .din(fa_out[1]), .full(lco_full), .dout(lco_q)
  );

  st_link #(.W(1)) u_sbit (
    .clk(clk), .rst_n(rst_n), .fill(fire_add), .drain(fire_sum),
    .din(fa_out[0]), .full(ls_full), .dout(ls_q)
  );

  // sum bits enter at the top and move down, so bit 0 lands last at position 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        acc <= '0;
    else if (fire_sum) acc <= {ls_q, acc[N-1:1]};
  end

  st_link #(.W(N + 1)) u_result (
    .clk(clk), .rst_n(rst_n), .fill(fire_res), .drain(res_valid & res_ready),
    .din({lc_q, acc}), .full(res_valid), .dout(res_data)
  );

  assign quiet = ~(|req_full | |bit_full | lc_full | ls_full | lco_full |
                   ctl_full | ctl2_full | mark_full);
  assign in_ready = quiet & ~res_valid;
endmodule

// File: rtl/st_serial_adder_chk.sv
`timescale 1ns/1ps
module st_serial_adder_chk #(
  parameter int N  = 32,
  parameter int CW = $clog2(N + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [N-1:0]  in_a,
  input logic [N-1:0]  in_b,
  input logic          in_cin,
  input logic [7:0]    go_i,
  input logic          res_valid,
  input logic          res_ready,
  input logic [N:0]    res_data,
  input logic [1:0]    bit_full,
  input logic [CW-1:0] ctl_count
);
  logic [N:0] owed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   owed <= '0;
    else if (in_valid && in_ready) owed <= {1'b0, in_a} + {1'b0, in_b} + {{N{1'b0}}, in_cin};
  end

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  a_r4_sum_matches: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> (res_data == owed));

  a_r5_opa_needs_go: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bit_full[0]) |-> $past(go_i[0]));

  a_r5_opb_needs_go: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bit_full[1]) |-> $past(go_i[1]));

  a_r5_res_needs_go: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(go_i[7]));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  a_r7_reopen: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> in_ready);

  a_r8_result_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !in_ready);

  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_count <= CW'(N));
endmodule

bind st_serial_adder st_serial_adder_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_a(in_a), .in_b(in_b), .in_cin(in_cin), .go_i(go_i),
  .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
  .bit_full(bit_full), .ctl_count(ctl_count)
);

// File: tb/sim_st_serial_adder.sv
`timescale 1ns/1ps
module sim_st_serial_adder;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [N-1:0] in_a = '0, in_b = '0;
  logic         in_cin = 1'b0;
  logic [7:0]   go_i = 8'hFF;
  logic         res_valid;
  logic         res_ready = 1'b0;
  logic [N:0]   res_data;

  int errors = 0;
  int checks = 0;
  int go_mode = 0;   // 0 all high, 1 random, 2 all low

  always #2.5 clk = ~clk;

  st_serial_adder #(.N(N)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_cin(in_cin), .go_i(go_i),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data)
  );

  task automatic check(input bit ok, input string req, input logic [N:0] act, input logic [N:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  always @(posedge clk) begin
    #2;
    case (go_mode)
      0:       go_i = 8'hFF;
      1:       go_i = 8'($urandom);
      default: go_i = 8'h00;
    endcase
  end

  // behavioural model: owed sum and busy state, compared on every clock
  bit         busy = 1'b0;
  bit         seen = 1'b0;
  logic [N:0] exp_sum = '0;
  logic [N:0] held = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      check(in_ready == !busy, "R2 in_ready follows busy state", N'(in_ready), N'(!busy));
      if (!busy) check(!res_valid, "R8 no result while idle", N'(res_valid), '0);
      if (busy && res_valid) begin
        if (!seen) begin
          seen = 1'b1;
          held = res_data;
          check(res_data == exp_sum, "R4 sum on first valid cycle", res_data, exp_sum);
        end else begin
          check(res_data == held, "R7 result stable while held", res_data, held);
        end
      end
      if (in_valid && in_ready) begin
        busy = 1'b1;
        seen = 1'b0;
        exp_sum = {1'b0, in_a} + {1'b0, in_b} + {{N{1'b0}}, in_cin};
      end
      if (res_valid && res_ready) busy = 1'b0;
    end
  end

  task automatic run_op(input logic [N-1:0] a, input logic [N-1:0] b, input logic c,
                        input int hold, input bit junk, input int exp_lat, input int stall);
    int n;
    logic [N:0] want;
    want = {1'b0, a} + {1'b0, b} + {{N{1'b0}}, c};
    @(posedge clk); #1;
    in_valid = 1'b1; in_a = a; in_b = b; in_cin = c;
    n = 0;
    do begin @(negedge clk); n++; end while (!in_ready && n < 1000);
    @(posedge clk); #1;   // accepting edge has passed
    if (junk) begin
      in_a = ~a; in_b = a ^ b; in_cin = ~c;
    end else begin
      in_valid = 1'b0;
    end
    if (stall > 0) begin
      go_mode = 2;
      repeat (stall) @(negedge clk);
      check(!res_valid, "R5 no result with go low", N'(res_valid), '0);
      check(!in_ready, "R5 still busy with go low", N'(in_ready), '0);
      go_mode = 1;
    end
    n = 0;
    do begin @(negedge clk); n++; end while (!res_valid && n < 20000);
    if (!res_valid) begin
      check(1'b0, "R6 result never became valid", '0, 1);
      in_valid = 1'b0;
      return;
    end
    // latency in negedges from the accepting edge: edge k is followed by negedge k+1
    if (exp_lat > 0) check(n == exp_lat, "R6 all-go latency", n, exp_lat);
    if (junk) check(res_data == want, "R3 busy-time inputs ignored", res_data, want);
    else      check(res_data == want, "R4 sum", res_data, want);
    if (hold > 0) begin
      repeat (hold) @(negedge clk);
      check(res_valid, "R7 valid held under back-pressure", N'(res_valid), 1);
      check(res_data == want, "R7 data held under back-pressure", res_data, want);
    end
    @(posedge clk); #1;
    res_ready = 1'b1;
    @(posedge clk); #1;
    res_ready = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    check(in_ready, "R7 ready returns after handshake", N'(in_ready), 1);
    check(!res_valid, "R8 result link emptied", N'(res_valid), '0);
  endtask

  initial begin
    #(200000.0 * 5.0);
    check(1'b0, "R6 watchdog expired", '0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(in_ready, "R1 in_ready in reset", N'(in_ready), 1);
    check(!res_valid, "R1 res_valid in reset", N'(res_valid), '0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready, "R1 in_ready after reset", N'(in_ready), 1);
    check(!res_valid, "R1 res_valid after reset", N'(res_valid), '0);

    // all joints enabled: fixed schedule of 5N+1 edges
    go_mode = 0;
    run_op('0, '0, 1'b0, 0, 1'b0, 5 * N + 2, 0);
    run_op('1, '1, 1'b1, 3, 1'b0, 5 * N + 2, 0);

    // random schedules, corner operands
    go_mode = 1;
    run_op('1, 32'h1, 1'b0, 7, 1'b1, 0, 0);
    run_op(32'h8000_0000, 32'h8000_0000, 1'b0, 0, 1'b0, 0, 0);
    run_op(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, 2, 1'b1, 0, 0);

    // stall mid-addition with every go bit low
    run_op(32'h1234_5678, 32'h9ABC_DEF0, 1'b1, 1, 1'b0, 0, 60);

    for (int i = 0; i < 20; i++) begin
      run_op(32'($urandom), 32'($urandom), 1'($urandom), int'($urandom_range(0, 5)),
             1'(i % 2), 0, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule